// File: doc/BRIEF.md
# Transmit Byte Queue with Bulk Commit

This block is the storage side of a serial transmitter. The host stages bytes through a write window whose offset 0 always aliases the queue's current write pointer, so a run of bytes is laid down at window offsets 0, 1, 2 and so on. The staged bytes stay invisible to the transmitter until the host writes a byte count to the commit port. A commit moves the write pointer forward and raises the fill count by that count, both in one cycle.

The transmitter drains the queue one byte per pop request. A status word packs the write pointer and the fill count so the host reads both at once. A space-available flag compares the fill against a threshold picked by a 3-bit level. An empty flag shows a drained queue. A commit larger than the free space is trimmed to fit and leaves a sticky overflow flag.

Top module: `txf_commit_fifo`

## Requirements
- R1: After reset the write pointer, the read pointer and the fill count are 0, `fifo_empty` is 1, `commit_err` is 0 and `pop_valid` is 0.
- R2: A window write at offset k stores its byte at queue slot (write pointer + k) modulo the depth. After a commit, these bytes pop in ascending slot order.
- R3: A commit of N bytes, with N no larger than the free space, advances the write pointer by N modulo the depth and raises the fill count by N in the next cycle. With no commit, the write pointer holds.
- R4: `ctl_rdata` carries the write pointer in bits [AW-1:0] and the fill count in bits [16+AW-1:16]. Every other bit is 0.
- R5: A pop request while the fill is non-zero gives `pop_valid`=1 in the next cycle, with `pop_data` equal to the oldest committed byte, and lowers the fill by 1.
- R6: A pop request while the fill is 0 is ignored. No `pop_valid` follows, the fill stays 0 and the read position is unchanged.
- R7: `space_avail` is 1 exactly when fill <= (4 << `cfg_level`).
- R8: `fifo_empty` is 1 exactly when the fill count is 0.
- R9: The usable capacity is DEPTH-1 bytes. A commit of N greater than the free space (capacity - fill) commits only the free space, and sets `commit_err`. `commit_err` stays set until reset.
- R10: A commit and an accepted pop in the same cycle change the fill by N-1.
- R11: The write and read pointers wrap from DEPTH-1 to 0 without losing byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Window byte write strobe |
| win_addr | input | AW | Window offset relative to the write pointer |
| win_wdata | input | 8 | Window byte |
| commit_we | input | 1 | Commit strobe |
| commit_cnt | input | AW | Number of staged bytes to commit |
| cfg_level | input | 3 | Space threshold level, threshold = 4 << level |
| pop_req | input | 1 | Transmitter request for one byte |
| pop_valid | output | 1 | Popped byte present this cycle |
| pop_data | output | 8 | Popped byte |
| ctl_rdata | output | 32 | Packed write pointer and fill count |
| space_avail | output | 1 | Fill at or below the threshold |
| fifo_empty | output | 1 | Fill count is zero |
| commit_err | output | 1 | Sticky over-capacity commit flag |

## Verification
The bench builds the block with AW=6, a 64-slot queue holding at most 63 bytes. With this size the random traffic wraps both pointers many times and runs into the capacity clamp often. The level thresholds 4 to 32 land inside the fill range, and levels 4 to 7 give thresholds above the capacity, so the flag stays high there. Mixed window writes, commits and pops, including commits and pops in the same cycle, are checked against a byte-accurate model of the queue.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int DATA_W   = 8;
    localparam int LVL_W    = 3;
    localparam int FILL_LSB = 16;
    localparam int CTL_W    = 32;
endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_we,
    input  logic [AW-1:0] commit_cnt,
    input  logic          pop_req,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW-1:0] fill,
    output logic          err,
    output logic          pop_ok,
    output logic          pop_valid
);
    localparam logic [AW-1:0] CAP = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW-1:0] fill;
        logic          err;
        logic          pv;
    } state_t;

    state_t st_d, st_q;
    logic [AW-1:0] free_c;
    logic [AW-1:0] take_c;
    logic          over_c;

    always_comb begin
        free_c = CAP - st_q.fill;
        over_c = commit_we && (commit_cnt > free_c);
        take_c = '0;
        if (commit_we) begin
            take_c = over_c ? free_c : commit_cnt;
        end
        pop_ok     = pop_req && (st_q.fill != '0);
        st_d       = st_q;
        st_d.wptr  = st_q.wptr + take_c;
        st_d.rptr  = st_q.rptr + AW'(pop_ok);
        st_d.fill  = st_q.fill + take_c - AW'(pop_ok);
        st_d.err   = st_q.err | over_c;
        st_d.pv    = pop_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr      = st_q.wptr;
    assign rptr      = st_q.rptr;
    assign fill      = st_q.fill;
    assign err       = st_q.err;
    assign pop_valid = st_q.pv;

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && st_q.fill == '0 && !commit_we) |=> (st_q.fill == '0 && !pop_valid));

    // R3
    wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_we |=> $stable(st_q.wptr));

    // R5
    pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> (pop_valid == ($past(st_q.fill) != '0)));

    // R10
    pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_we && pop_req && st_q.fill != '0) |=> (st_q.fill == $past(st_q.fill) - 1'b1));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int AW = 10
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [txf_pkg::DATA_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_idx,
    output logic [txf_pkg::DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [txf_pkg::DATA_W-1:0] mem_q [DEPTH];
    logic [txf_pkg::DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem_q[rd_idx];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/txf_level.sv
module txf_level #(
    parameter int AW = 10
) (
    input  logic [AW-1:0]              fill,
    input  logic [txf_pkg::LVL_W-1:0]  level,
    output logic                       below
);
    localparam int TW = AW + 8;

    logic [TW-1:0] thr_c;

    always_comb begin
        thr_c = TW'(4) << level;
        below = (TW'(fill) <= thr_c);
    end
endmodule

// File: rtl/txf_commit_fifo.sv
module txf_commit_fifo #(
    parameter int AW = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_we,
    input  logic [AW-1:0]               win_addr,
    input  logic [txf_pkg::DATA_W-1:0]  win_wdata,
    input  logic                        commit_we,
    input  logic [AW-1:0]               commit_cnt,
    input  logic [txf_pkg::LVL_W-1:0]   cfg_level,
    input  logic                        pop_req,
    output logic                        pop_valid,
    output logic [txf_pkg::DATA_W-1:0]  pop_data,
    output logic [txf_pkg::CTL_W-1:0]   ctl_rdata,
    output logic                        space_avail,
    output logic                        fifo_empty,
    output logic                        commit_err
);
    logic [AW-1:0] wptr, rptr, fill;
    logic          pop_ok;
    logic [AW-1:0] wr_idx;

    txf_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_we  (commit_we),
        .commit_cnt (commit_cnt),
        .pop_req    (pop_req),
        .wptr       (wptr),
        .rptr       (rptr),
        .fill       (fill),
        .err        (commit_err),
        .pop_ok     (pop_ok),
        .pop_valid  (pop_valid)
    );

    assign wr_idx = wptr + win_addr;

    txf_store #(.AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (win_we),
        .wr_idx  (wr_idx),
        .wr_data (win_wdata),
        .rd_en   (pop_ok),
        .rd_idx  (rptr),
        .rd_data (pop_data)
    );

    txf_level #(.AW(AW)) u_level (
        .fill  (fill),
        .level (cfg_level),
        .below (space_avail)
    );

    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[AW-1:0] = wptr;
        ctl_rdata[txf_pkg::FILL_LSB +: AW] = fill;
        fifo_empty = (fill == '0);
    end

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !commit_we) |=> !pop_valid);
endmodule

// File: tb/txf_commit_fifo_test.sv
`timescale 1ns/1ps
module txf_commit_fifo_test;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int CAP   = DEPTH - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          win_we;
    logic [AW-1:0] win_addr;
    logic [7:0]    win_wdata;
    logic          commit_we;
    logic [AW-1:0] commit_cnt;
    logic [2:0]    cfg_level;
    logic          pop_req;
    logic          pop_valid;
    logic [7:0]    pop_data;
    logic [31:0]   ctl_rdata;
    logic          space_avail, fifo_empty, commit_err;

    always #2 clk = ~clk;

    txf_commit_fifo #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_addr(win_addr),
        .win_wdata(win_wdata), .commit_we(commit_we), .commit_cnt(commit_cnt),
        .cfg_level(cfg_level), .pop_req(pop_req), .pop_valid(pop_valid),
        .pop_data(pop_data), .ctl_rdata(ctl_rdata), .space_avail(space_avail),
        .fifo_empty(fifo_empty), .commit_err(commit_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_mem [DEPTH];
    int m_wptr, m_rptr, m_fill;
    bit m_err, m_pv;
    logic [7:0] m_pd;

    function automatic logic [31:0] pack_ctl(int wp, int fl);
        logic [31:0] v;
        v = '0;
        v[AW-1:0]  = AW'(wp);
        v[16 +: AW] = AW'(fl);
        return v;
    endfunction

    function automatic bit exp_space(int fl, int lvl);
        return fl <= (4 << lvl);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        check("R3 R4 R11 ctl_rdata", ctl_rdata, pack_ctl(m_wptr, m_fill));
        check("R8 fifo_empty", 32'(fifo_empty), 32'(m_fill == 0));
        check("R7 space_avail", 32'(space_avail), 32'(exp_space(m_fill, int'(cfg_level))));
        check("R9 commit_err", 32'(commit_err), 32'(m_err));
        check("R5 R6 pop_valid", 32'(pop_valid), 32'(m_pv));
        if (m_pv) check("R2 R5 pop_data", 32'(pop_data), 32'(m_pd));
    endtask

    task automatic clear_in();
        win_we = 0; win_addr = '0; win_wdata = '0;
        commit_we = 0; commit_cnt = '0; pop_req = 0;
    endtask

    // Drive at negedge beforehand; model the edge; compare at next negedge.
    task automatic tick();
        int free, take;
        bit pok;
        @(posedge clk);
        pok  = pop_req && (m_fill > 0);
        m_pv = pok;
        if (pok) begin
            m_pd   = m_mem[m_rptr];
            m_rptr = (m_rptr + 1) % DEPTH;
        end
        if (win_we) m_mem[(m_wptr + int'(win_addr)) % DEPTH] = win_wdata;
        take = 0;
        if (commit_we) begin
            free = CAP - m_fill;
            take = (int'(commit_cnt) > free) ? free : int'(commit_cnt);
            if (int'(commit_cnt) > free) m_err = 1;
            m_wptr = (m_wptr + take) % DEPTH;
        end
        m_fill = m_fill + take - (pok ? 1 : 0);
        @(negedge clk);
        clear_in();
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_wptr = 0; m_rptr = 0; m_fill = 0; m_err = 0; m_pv = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        cfg_level = 3'd5;
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 reset ctl", ctl_rdata, 32'h0);
        check("R1 reset empty", 32'(fifo_empty), 32'h1);
        check("R1 reset err", 32'(commit_err), 32'h0);
        check("R1 reset pop_valid", 32'(pop_valid), 32'h0);

        // R2 preload every slot through the window
        for (int i = 0; i < DEPTH; i++) begin
            win_we = 1; win_addr = AW'(i); win_wdata = 8'(i ^ 8'hA5);
            tick();
        end
        // R3 commit 10
        commit_we = 1; commit_cnt = AW'(10);
        tick();
        // R5 drain them
        for (int i = 0; i < 10; i++) begin
            pop_req = 1;
            tick();
        end
        // R6 pops on empty are ignored
        for (int i = 0; i < 3; i++) begin
            pop_req = 1;
            tick();
        end
        commit_we = 1; commit_cnt = AW'(2);
        tick();
        pop_req = 1; tick();   // R6 order intact: slot 10 expected
        pop_req = 1; tick();
        // R7 level sweep with 20 bytes queued
        commit_we = 1; commit_cnt = AW'(20);
        tick();
        for (int l = 0; l < 8; l++) begin
            cfg_level = 3'(l);
            tick();
        end
        // R10 commit together with pop
        commit_we = 1; commit_cnt = AW'(5); pop_req = 1;
        tick();
        // R9 over-capacity commit clamps
        commit_we = 1; commit_cnt = AW'(CAP);
        tick();
        tick();
        // R9 flag cleared only by reset
        do_reset();
        @(negedge clk);
        check("R1 R9 err after reset", 32'(commit_err), 32'h0);

        // random traffic, R11 wraparound
        for (int c = 0; c < 5000; c++) begin
            int free;
            free = CAP - m_fill;
            if (free > 0 && ($urandom % 2) == 1) begin
                win_we = 1;
                win_addr = AW'($urandom % free);
                win_wdata = 8'($urandom);
            end
            if (($urandom % 4) == 0) begin
                commit_we = 1;
                commit_cnt = AW'($urandom % ((($urandom % 16) == 0) ? DEPTH : 9));
            end
            pop_req = (($urandom % 3) != 0);
            if (($urandom % 64) == 0) cfg_level = 3'($urandom);
            tick();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule